// File: doc/BRIEF.md
# Duty-Cycled ADC Sampling Sequencer

This block decides when an external multi-channel ADC is powered and which channel it converts. It runs on a slow always-on clock. Software-facing settings arrive as plain inputs: enable, low-power mode, oneshot mode, power-up time, wake interval and two match counts. A filter stage outside the block reports, with every converted sample, whether that sample satisfied its conditions. The sequencer asks for the channels in order, one per sampling round, and waits for the converter's data-valid signal before it takes each one.

In low-power mode the converter is duty-cycled. It powers up, settles, runs one round and then powers down for a programmed interval. This repeats until a programmed number of consecutive rounds have matched. From then on the converter stays powered and the block samples back to back. A debounced match needs a second, separate count of consecutive matching rounds, and it is reported as a one-cycle strobe. A mismatch during continuous sampling sends the block back to duty-cycling. Without low-power mode only the continuous count applies. Oneshot mode runs a single round, pulses a completion strobe whatever the filter said, and leaves the converter off. Clearing the enable, or holding the software reset, forces the idle powered-down state.

Top module: `lp_adc_seq`

## Requirements
- R1: While `enable_i` is low or `sw_rst_i` is high, the cycle after shows `pd_o`=1, `chan_o`=0 and no strobes, and the match count is cleared. On release the block starts again from power-up.
- R2: After power-up starts (`pd_o` falls), `pd_o` stays low with `chan_o`=0 for exactly `pwrup_time_i`+2 cycles before the first channel request.
- R3: `chan_o` is one-hot, with bit k requesting channel k. Channels are requested in ascending order within a round. The block moves to the next channel only on a cycle with `data_valid_i`=1 and otherwise holds the request.
- R4: A round counts as matching only if `match_i` was 1 on the accepted sample of every channel. A miss on any single channel spoils the round.
- R5: In continuous sampling, `match_done_o` pulses for one cycle after `np_count_i` consecutive matching rounds. The count then restarts from zero and sampling continues.
- R6: A non-matching round clears the consecutive-match count in either phase.
- R7: In low-power mode, each duty-cycled round that does not complete the low-power count is followed by `pd_o`=1 for exactly `wakeup_time_i`+1 cycles, then a new power-up.
- R8: In low-power mode, the round that completes `lp_count_i` consecutive matches keeps the converter powered. Continuous sampling then begins with its count at zero, so the first debounced match comes after `lp_count_i`+`np_count_i` rounds.
- R9: A non-matching round in continuous sampling returns the block to duty-cycling when `lp_mode_i`=1. When `lp_mode_i`=0 it goes on sampling without powering down.
- R10: With `oneshot_i`=1 the block runs exactly one round and pulses `oneshot_done_o` once, whatever `match_i` was. It never pulses `match_done_o`, and it stays powered down until the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | always-on clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| enable_i | input | 1 | run the sequencer; low forces idle and power-down |
| sw_rst_i | input | 1 | synchronous clear of all states and counters while high |
| lp_mode_i | input | 1 | enable duty-cycled low-power phase |
| oneshot_i | input | 1 | single round, completion regardless of filter |
| pwrup_time_i | input | 4 | power-up wait in cycles |
| wakeup_time_i | input | 24 | power-down interval between low-power rounds |
| lp_count_i | input | 8 | consecutive matching rounds to leave low-power phase |
| np_count_i | input | 16 | consecutive matching rounds for a debounced match |
| data_valid_i | input | 1 | converter sample valid for the requested channel |
| match_i | input | 1 | filter result for the current sample |
| pd_o | output | 1 | converter power-down request |
| chan_o | output | 2 | one-hot channel request |
| match_done_o | output | 1 | one-cycle debounced match strobe |
| oneshot_done_o | output | 1 | one-cycle oneshot completion strobe |

## Verification
The bench sweeps every power-up time to pin down the settle delay. It runs continuous sampling with no misses and with a miss placed on a chosen channel in a chosen round, so that the count clear can be told apart from a mere pause, and a miss on channel 0 from one on channel 1. Low-power runs use several wake intervals, with a miss in either phase; counting power-down episodes and rounds separates the two counters and shows the return to duty-cycling. Stalled data-valid, oneshot with failing filters, software reset in mid-count and enable removal cover the remaining paths.

// File: rtl/lp_adc_seq_pkg.sv
package lp_adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_PWRUP, ST_SETTLE, ST_SAMPLE, ST_SLEEP, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/lp_adc_seq_timer.sv
module lp_adc_seq_timer #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/lp_adc_seq_run_cnt.sv
module lp_adc_seq_run_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         reach_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  assign nxt     = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  // limit 0 behaves like 1
  assign reach_o = nxt >= {1'b0, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= nxt[W-1:0];
  end
endmodule

// File: rtl/lp_adc_seq.sv
module lp_adc_seq
  import lp_adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned PWR_W  = 4,
  parameter int unsigned WAKE_W = 24,
  parameter int unsigned LP_W   = 8,
  parameter int unsigned NP_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              sw_rst_i,
  input  logic              lp_mode_i,
  input  logic              oneshot_i,
  input  logic [PWR_W-1:0]  pwrup_time_i,
  input  logic [WAKE_W-1:0] wakeup_time_i,
  input  logic [LP_W-1:0]   lp_count_i,
  input  logic [NP_W-1:0]   np_count_i,
  input  logic              data_valid_i,
  input  logic              match_i,
  output logic              pd_o,
  output logic [NUM_CH-1:0] chan_o,
  output logic              match_done_o,
  output logic              oneshot_done_o
);
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned CNT_W = (NP_W > LP_W) ? NP_W : LP_W;
  localparam int unsigned TMR_W = (WAKE_W > PWR_W) ? WAKE_W : PWR_W;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            acc_q, acc_d;
  logic            lp_phase_q, lp_phase_d;
  logic            md_d, od_d;
  logic            halt, round_ok, tmr_hit, reach, cnt_clr, cnt_inc;
  logic [TMR_W-1:0] tmr_limit;
  logic [CNT_W-1:0] cnt_limit;

  assign halt      = !enable_i || sw_rst_i;
  assign round_ok  = (ch_q == '0) ? match_i : (acc_q & match_i);
  assign tmr_limit = (state_q == ST_PWRUP) ? TMR_W'(pwrup_time_i) : TMR_W'(wakeup_time_i);
  assign cnt_limit = lp_phase_q ? CNT_W'(lp_count_i) : CNT_W'(np_count_i);

  lp_adc_seq_timer #(.W(TMR_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_d != state_q),
    .limit_i (tmr_limit),
    .hit_o   (tmr_hit)
  );

  lp_adc_seq_run_cnt #(.W(CNT_W)) u_run_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .limit_i (cnt_limit),
    .reach_o (reach)
  );

  always_comb begin
    state_d    = state_q;
    ch_d       = ch_q;
    acc_d      = acc_q;
    lp_phase_d = lp_phase_q;
    md_d       = 1'b0;
    od_d       = 1'b0;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    if (halt) begin
      state_d = ST_OFF;
      ch_d    = '0;
      cnt_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d    = ST_PWRUP;
          lp_phase_d = lp_mode_i;
          cnt_clr    = 1'b1;
        end
        ST_PWRUP:  if (tmr_hit) state_d = ST_SETTLE;
        ST_SETTLE: begin
          state_d = ST_SAMPLE;
          ch_d    = '0;
        end
        ST_SAMPLE: if (data_valid_i) begin
          acc_d = round_ok;
          if (ch_q != LAST_CH) begin
            ch_d = ch_q + 1'b1;
          end else begin
            ch_d = '0;
            if (oneshot_i) begin
              od_d    = 1'b1;
              state_d = ST_DONE;
            end else if (!round_ok) begin
              cnt_clr = 1'b1;
              if (lp_mode_i) begin
                lp_phase_d = 1'b1;
                state_d    = ST_SLEEP;
              end
            end else if (reach) begin
              cnt_clr = 1'b1;
              if (lp_phase_q) lp_phase_d = 1'b0;  // stay powered
              else            md_d       = 1'b1;
            end else begin
              cnt_inc = 1'b1;
              if (lp_phase_q) state_d = ST_SLEEP;
            end
          end
        end
        ST_SLEEP: if (tmr_hit) state_d = ST_PWRUP;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_OFF;
      ch_q           <= '0;
      acc_q          <= 1'b0;
      lp_phase_q     <= 1'b0;
      match_done_o   <= 1'b0;
      oneshot_done_o <= 1'b0;
    end else begin
      state_q        <= state_d;
      ch_q           <= ch_d;
      acc_q          <= acc_d;
      lp_phase_q     <= lp_phase_d;
      match_done_o   <= md_d;
      oneshot_done_o <= od_d;
    end
  end

  assign pd_o = (state_q == ST_OFF) || (state_q == ST_SLEEP) || (state_q == ST_DONE);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign chan_o[g] = (state_q == ST_SAMPLE) && (ch_q == CH_W'(g));
  end
endmodule

// File: rtl/lp_adc_seq_chk.sv
module lp_adc_seq_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              sw_rst_i,
  input logic              oneshot_i,
  input logic              data_valid_i,
  input logic              pd_o,
  input logic [NUM_CH-1:0] chan_o,
  input logic              match_done_o,
  input logic              oneshot_done_o
);
  assert_halt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i || sw_rst_i) |=> (pd_o && chan_o == '0 && !match_done_o && !oneshot_done_o));

  assert_settle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_o) |-> chan_o == '0);

  assert_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_o));

  for (genvar i = 1; i < NUM_CH; i++) begin : g_order
    assert_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(chan_o[i]) |-> $past(chan_o[i-1] && data_valid_i));
  end

  assert_chan_pwr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_o != '0) |-> !pd_o);

  assert_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_done_o |=> !match_done_o);

  assert_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_done_o |-> $past(data_valid_i && chan_o[NUM_CH-1]));

  assert_oneshot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oneshot_done_o |-> ($past(oneshot_i && data_valid_i) && !match_done_o));

  assert_oneshot_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oneshot_done_o |=> pd_o);
endmodule

bind lp_adc_seq lp_adc_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enable_i       (enable_i),
  .sw_rst_i       (sw_rst_i),
  .oneshot_i      (oneshot_i),
  .data_valid_i   (data_valid_i),
  .pd_o           (pd_o),
  .chan_o         (chan_o),
  .match_done_o   (match_done_o),
  .oneshot_done_o (oneshot_done_o)
);

// File: tb/lp_adc_seq_tb.sv
module lp_adc_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0, sw_rst_i = 1'b0, lp_mode_i = 1'b0, oneshot_i = 1'b0;
  logic [3:0]  pwrup_time_i = '0;
  logic [23:0] wakeup_time_i = '0;
  logic [7:0]  lp_count_i = 8'd1;
  logic [15:0] np_count_i = 16'd1;
  logic        data_valid_i = 1'b0, match_i = 1'b0;
  logic        pd_o, match_done_o, oneshot_done_o;
  logic [1:0]  chan_o;

  always #5 clk_i = ~clk_i;

  lp_adc_seq u_dut (
    .clk_i, .rst_ni, .enable_i, .sw_rst_i, .lp_mode_i, .oneshot_i,
    .pwrup_time_i, .wakeup_time_i, .lp_count_i, .np_count_i,
    .data_valid_i, .match_i, .pd_o, .chan_o, .match_done_o, .oneshot_done_o
  );

  int checks = 0, errors = 0;
  int rnd, strobes, first_rnd, pd_rises, osd, pre, run, last_run;
  int fail_rnd, fail_chan;
  logic seen, pd_prev, dv_en;
  logic [1:0] first_chan;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // observe outputs of the last edge, then drive inputs for the next one
  task automatic cyc();
    @(negedge clk_i);
    if (match_done_o) begin
      strobes++;
      if (first_rnd < 0) first_rnd = rnd;
    end
    if (oneshot_done_o) osd++;
    if (pd_o && !pd_prev) pd_rises++;
    pd_prev = pd_o;
    if (pd_o) run++;
    else if (run > 0) begin last_run = run; run = 0; end
    if (!seen) begin
      if (chan_o != 2'b00) begin seen = 1'b1; first_chan = chan_o; end
      else if (!pd_o) pre++;
    end
    match_i = !(fail_rnd == rnd &&
                ((fail_chan == 0 && chan_o == 2'b01) || (fail_chan == 1 && chan_o == 2'b10)));
    data_valid_i = dv_en;
    if (chan_o == 2'b10 && dv_en) rnd++;
  endtask

  task automatic clr_stats();
    rnd = 0; strobes = 0; first_rnd = -1; pd_rises = 0; osd = 0;
    pre = 0; run = 0; last_run = 0; seen = 1'b0; pd_prev = pd_o;
  endtask

  task automatic start(input logic lp, input logic os, input int pw, input int w,
                       input int l, input int n);
    enable_i = 1'b0; sw_rst_i = 1'b0;
    lp_mode_i = lp; oneshot_i = os;
    pwrup_time_i = 4'(pw); wakeup_time_i = 24'(w);
    lp_count_i = 8'(l); np_count_i = 16'(n);
    fail_rnd = -1; fail_chan = 0; dv_en = 1'b1;
    cyc(); cyc();
    clr_stats();
    enable_i = 1'b1;
  endtask

  task automatic to_strobe();
    for (int i = 0; i < 5000 && first_rnd < 0; i++) cyc();
  endtask

  initial begin
    #1_900_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fail_rnd = -1; fail_chan = 0; dv_en = 1'b1;
    clr_stats();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cyc();
    chk("R1 reset pd", int'(pd_o), 1);
    chk("R1 reset chan", int'(chan_o), 0);
    chk("R1 reset match strobe", int'(match_done_o), 0);
    chk("R1 reset oneshot strobe", int'(oneshot_done_o), 0);

    // R2 / R3: power-up settle and channel order over every power-up time
    for (int pw = 0; pw < 16; pw++) begin
      start(1'b0, 1'b0, pw, 0, 1, 1000);
      for (int i = 0; i < 40 && !seen; i++) cyc();
      chk($sformatf("R2 settle pw=%0d", pw), pre, pw + 2);
      chk("R3 first channel", int'(first_chan), 1);
      cyc();
      chk("R3 second channel", int'(chan_o), 2);
    end

    // R3: hold channel while data_valid low
    start(1'b0, 1'b0, 1, 0, 1, 1000);
    dv_en = 1'b0;
    repeat (25) cyc();
    chk("R3 stall holds ch0", int'(chan_o), 1);
    chk("R3 stall no round", rnd, 0);
    dv_en = 1'b1;
    cyc(); cyc();
    chk("R3 advance on valid", int'(chan_o), 2);

    // R5: continuous debounce for several counts
    for (int n = 1; n <= 5; n++) begin
      start(1'b0, 1'b0, 2, 0, 1, n);
      to_strobe();
      chk($sformatf("R5 np_count=%0d", n), first_rnd, n);
      chk("R9 no power-down without lp", pd_rises, 0);
    end

    // R5: restart after strobe
    start(1'b0, 1'b0, 1, 0, 1, 2);
    for (int i = 0; i < 200 && rnd < 6; i++) cyc();
    cyc();
    chk("R5 restart strobes", strobes, 3);

    // R4 / R6: a miss on either channel clears the count
    for (int c = 0; c < 2; c++) begin
      for (int f = 0; f < 3; f++) begin
        start(1'b0, 1'b0, 0, 0, 1, 3);
        fail_chan = c; fail_rnd = f;
        to_strobe();
        chk($sformatf("R4 R6 miss ch%0d rnd%0d", c, f), first_rnd, f + 1 + 3);
        chk("R9 continues without lp", pd_rises, 0);
      end
    end

    // R7 / R8: duty cycle length and phase switch
    for (int w = 0; w < 8; w += 3) begin
      for (int l = 1; l <= 3; l++) begin
        start(1'b1, 1'b0, 1, w, l, 2);
        to_strobe();
        chk($sformatf("R8 rounds w=%0d l=%0d", w, l), first_rnd, l + 2);
        chk("R7 sleeps", pd_rises, l - 1);
        if (l > 1) chk("R7 sleep length", last_run, w + 1);
      end
    end

    // R6: miss in low-power phase
    start(1'b1, 1'b0, 1, 2, 3, 1);
    fail_chan = 1; fail_rnd = 1;
    to_strobe();
    chk("R6 lp miss rounds", first_rnd, 1 + 1 + 3 + 1);
    chk("R6 lp miss sleeps", pd_rises, 4);

    // R9: miss in continuous phase returns to duty-cycling
    start(1'b1, 1'b0, 1, 2, 2, 3);
    fail_chan = 0; fail_rnd = 3;
    to_strobe();
    chk("R9 np miss rounds", first_rnd, 3 + 1 + 2 + 3);
    chk("R9 np miss sleeps", pd_rises, 3);

    // R10: oneshot ignores filter
    start(1'b0, 1'b1, 1, 0, 1, 1);
    fail_chan = 0; fail_rnd = 0;
    repeat (30) cyc();
    chk("R10 oneshot strobes", osd, 1);
    chk("R10 no match strobe", strobes, 0);
    chk("R10 rounds", rnd, 1);
    chk("R10 powered down", int'(pd_o), 1);
    chk("R10 no channel", int'(chan_o), 0);

    // R1: software reset mid-count clears the count
    start(1'b0, 1'b0, 2, 0, 1, 3);
    for (int i = 0; i < 100 && rnd < 2; i++) cyc();
    sw_rst_i = 1'b1;
    cyc();
    chk("R1 sw reset pd", int'(pd_o), 1);
    chk("R1 sw reset chan", int'(chan_o), 0);
    repeat (3) cyc();
    chk("R1 sw reset held", int'(pd_o), 1);
    clr_stats();
    sw_rst_i = 1'b0;
    to_strobe();
    chk("R1 count cleared", first_rnd, 3);
    chk("R1 restart power-up", pre, 4);

    // R1: enable removal
    enable_i = 1'b0;
    cyc();
    chk("R1 disable pd", int'(pd_o), 1);
    chk("R1 disable chan", int'(chan_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule